// File: doc/BRIEF.md
# Indirect Operand Address Generator

This block supplies the data-memory address for every indirect operand access of a small signal-processing core. It keeps a file of auxiliary registers and a pointer that picks the current one. While an access is requested, the current register's value is driven as the address in the same cycle. At the closing clock edge the block post-modifies that register according to a three-bit mode code, and it can load a new pointer value in the same operation.

Besides stepping by one in either direction, the block can add or subtract register 0 as an index. It also has a reverse-carry form of that add and subtract, in which carries and borrows run from the most significant bit down toward bit 0. With register 0 set to half the transform length, repeated reverse-carry adds visit the bit-reversed sample order an FFT needs. A separate write port loads any register directly. Instruction decoding, the memory and direct addressing are handled elsewhere.

Top module: `ind_addr_gen`

## Requirements
- R1: An active-low asynchronous reset clears every auxiliary register and the pointer to zero.
- R2: `addr_out` always shows the current register's value before that cycle's modification, so an access gets its address in the same cycle.
- R3: Mode 0 (hold) and mode 7 (reserved) leave the register file unchanged while an access is requested.
- R4: Mode 1 adds one to the current register and mode 2 subtracts one, both modulo 2^16 (0xFFFF+1 gives 0, 0-1 gives 0xFFFF).
- R5: Mode 3 adds register 0 to the current register and mode 4 subtracts register 0, both modulo 2^16.
- R6: Mode 5 adds register 0 with carries that travel from the most significant bit toward bit 0, and drops the carry out of bit 0. With register 0 = 4 and a start of 0, eight steps give the addresses 0,4,2,6,1,5,3,7 and the register then returns to 0.
- R7: Mode 6 subtracts register 0 with borrows that travel from the most significant bit toward bit 0. With register 0 = 4 and a start of 0, it gives 0,7,3,5,1,6,2,4 and the register then returns to 0.
- R8: The register that gets modified is the one the pointer selected before the edge. When `ptr_ld` is high, the pointer takes `ptr_new` at that same edge, whether or not an access is requested.
- R9: When `wr_en` is high, register `wr_sel` takes `wr_data`. If that register is also the one being post-modified, the write wins and the modification is dropped. A write to a different register lets both updates happen.
- R10: When `acc_en` is low, the mode code has no effect on any register.
- R11: The index and increment modes use the value register 0 held before the edge, even when register 0 is the current register (register 0 = 4 with mode 3 gives 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | An indirect access is requested this cycle |
| acc_mode | input | 3 | Post-modify mode code (0..7) |
| ptr_ld | input | 1 | Load the pointer at this edge |
| ptr_new | input | 3 | New pointer value |
| wr_en | input | 1 | Direct register write |
| wr_sel | input | 3 | Register to write |
| wr_data | input | 16 | Write data |
| addr_out | output | 16 | Operand address (current register's value) |
| ptr_out | output | 3 | Current pointer |
| ar_flat | output | 128 | All registers, register i in bits [16*i+15:16*i] |

## Verification
Two updates can land on one register at one edge: the post-modification of the current register and a direct write through `wr_sel`. The bench provokes this by issuing an increment access while writing the same register, and then a second time while writing a different register. In the first case the register must hold exactly the written value with no increment applied. In the second case both registers must show their own update. The pointer load is also combined with a post-modify, to show that the modification lands on the register the old pointer selected.

// File: rtl/iag_pkg.sv
package iag_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    IAG_HOLD     = 3'd0,
    IAG_INC      = 3'd1,
    IAG_DEC      = 3'd2,
    IAG_ADD_IX   = 3'd3,
    IAG_SUB_IX   = 3'd4,
    IAG_RVADD_IX = 3'd5,
    IAG_RVSUB_IX = 3'd6,
    IAG_RSVD     = 3'd7
  } iag_mode_e;

  function automatic logic mode_modifies(input iag_mode_e m);
    return !(m == IAG_HOLD || m == IAG_RSVD);
  endfunction
endpackage

// File: rtl/iag_step.sv
module iag_step #(
  parameter int W = 16
) (
  input  iag_pkg::iag_mode_e mode,
  input  logic [W-1:0]       cur,
  input  logic [W-1:0]       idx,
  output logic [W-1:0]       nxt
);
  import iag_pkg::*;

  // carry enters at the MSB and ripples down toward bit 0
  function automatic logic [W-1:0] rc_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] s;
    logic c;
    c = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  // borrow enters at the MSB and ripples down toward bit 0
  function automatic logic [W-1:0] rc_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    logic br;
    br = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      d[i] = a[i] ^ b[i] ^ br;
      br   = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & br);
    end
    return d;
  endfunction

  always_comb begin
    unique case (mode)
      IAG_INC:      nxt = cur + W'(1);
      IAG_DEC:      nxt = cur - W'(1);
      IAG_ADD_IX:   nxt = cur + idx;
      IAG_SUB_IX:   nxt = cur - idx;
      IAG_RVADD_IX: nxt = rc_add(cur, idx);
      IAG_RVSUB_IX: nxt = rc_sub(cur, idx);
      default:      nxt = cur;
    endcase
  end
endmodule

// File: rtl/iag_ptr.sv
module iag_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (ld) ptr_q <= ld_val;
  end
endmodule

// File: rtl/iag_regfile.sv
module iag_regfile #(
  parameter int W     = 16,
  parameter int N     = 8,
  localparam int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [SEL_W-1:0] step_sel,
  input  logic [W-1:0]     step_val,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [N*W-1:0]   flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] r_q;
    logic         hit_wr, hit_step;
    assign hit_wr   = wr_en   && (wr_sel   == SEL_W'(g));
    assign hit_step = step_en && (step_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r_q <= '0;
      else if (hit_wr)   r_q <= wr_data;
      else if (hit_step) r_q <= step_val;
    end
    assign flat[g*W +: W] = r_q;
  end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
  parameter int DATA_W = 16,
  parameter int NUM_AR = 8,
  localparam int PTR_W = $clog2(NUM_AR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic [2:0]               acc_mode,
  input  logic                     ptr_ld,
  input  logic [PTR_W-1:0]         ptr_new,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        addr_out,
  output logic [PTR_W-1:0]         ptr_out,
  output logic [NUM_AR*DATA_W-1:0] ar_flat
);
  import iag_pkg::*;

  iag_mode_e         mode;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] ar_v [NUM_AR];
  logic [DATA_W-1:0] cur_val, idx_val, nxt_val;
  logic              step_fire;   // a post-modify is applied at this edge
  logic              wr_hit_cur;  // a direct write collides with it

  assign mode = iag_mode_e'(acc_mode);

  for (genvar g = 0; g < NUM_AR; g++) begin : g_view
    assign ar_v[g] = ar_flat[g*DATA_W +: DATA_W];
  end

  assign cur_val    = ar_v[ptr_q];
  assign idx_val    = ar_v[0];
  assign step_fire  = acc_en && mode_modifies(mode);
  assign wr_hit_cur = step_fire && wr_en && (wr_sel == ptr_q);

  iag_step #(.W(DATA_W)) u_step (
    .mode (mode),
    .cur  (cur_val),
    .idx  (idx_val),
    .nxt  (nxt_val)
  );

  iag_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ptr_ld),
    .ld_val (ptr_new),
    .ptr_q  (ptr_q)
  );

  iag_regfile #(.W(DATA_W), .N(NUM_AR)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_fire),
    .step_sel (ptr_q),
    .step_val (nxt_val),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .flat     (ar_flat)
  );

  assign addr_out = cur_val;
  assign ptr_out  = ptr_q;
endmodule

// File: rtl/iag_chk.sv
module iag_chk #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int PW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic [2:0]    acc_mode,
  input logic          ptr_ld,
  input logic [PW-1:0] ptr_new,
  input logic          wr_en,
  input logic [PW-1:0] wr_sel,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  addr_out,
  input logic [PW-1:0] ptr_out,
  input logic [N*W-1:0] ar_flat,
  input logic          step_fire,
  input logic          wr_hit_cur
);
  logic [W-1:0] cv [N];
  for (genvar g = 0; g < N; g++) begin : g_cv
    assign cv[g] = ar_flat[g*W +: W];
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ar_flat == '0 && ptr_out == '0));

  a_r2_addr_is_cur: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out == cv[ptr_out]);

  a_r4_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 3'd1 && !wr_en && !ptr_ld) |=> addr_out == $past(addr_out) + W'(1));

  a_r5_add_index: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 3'd3 && !wr_en && !ptr_ld) |=> addr_out == $past(addr_out) + $past(cv[0]));

  a_r8_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> ptr_out == $past(ptr_new));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_cur |=> cv[$past(wr_sel)] == $past(wr_data));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fire && !wr_en && !ptr_ld) |=> ($stable(ar_flat) && $stable(ptr_out)));
endmodule

bind ind_addr_gen iag_chk #(.W(DATA_W), .N(NUM_AR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_mode   (acc_mode),
  .ptr_ld     (ptr_ld),
  .ptr_new    (ptr_new),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .addr_out   (addr_out),
  .ptr_out    (ptr_out),
  .ar_flat    (ar_flat),
  .step_fire  (step_fire),
  .wr_hit_cur (wr_hit_cur)
);

// File: tb/ind_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ind_addr_gen_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         acc_en = 1'b0;
  logic [2:0]   acc_mode = 3'd0;
  logic         ptr_ld = 1'b0;
  logic [2:0]   ptr_new = 3'd0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = 3'd0;
  logic [15:0]  wr_data = 16'd0;
  logic [15:0]  addr_out;
  logic [2:0]   ptr_out;
  logic [127:0] ar_flat;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ind_addr_gen dut_i (.*);

  typedef struct {
    logic [15:0]  addr;
    logic [2:0]   ptr;
    logic [127:0] flat;
    string        tag;
  } item_t;

  item_t       sb_q[$];
  logic [15:0] m_ar [8];
  logic [2:0]  m_ptr;

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [127:0] m_flat();
    logic [127:0] f;
    for (int i = 0; i < 8; i++) f[i*16 +: 16] = m_ar[i];
    return f;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: apply one operation and push what the ports must show this cycle
  task automatic op(input bit en, input logic [2:0] md, input bit ld, input logic [2:0] np,
                    input bit we, input logic [2:0] ws, input logic [15:0] wd, input string tag);
    item_t it;
    logic [15:0] nv, ix;
    @(posedge clk); #2;
    acc_en = en; acc_mode = md; ptr_ld = ld; ptr_new = np;
    wr_en = we; wr_sel = ws; wr_data = wd;
    it.addr = m_ar[m_ptr]; it.ptr = m_ptr; it.flat = m_flat(); it.tag = tag;
    sb_q.push_back(it);
    ix = m_ar[0]; nv = m_ar[m_ptr];
    if (en) begin
      case (md)
        3'd1: nv = nv + 16'd1;
        3'd2: nv = nv - 16'd1;
        3'd3: nv = nv + ix;
        3'd4: nv = nv - ix;
        3'd5: nv = rev16(rev16(nv) + rev16(ix));
        3'd6: nv = rev16(rev16(nv) - rev16(ix));
        default: ;
      endcase
      m_ar[m_ptr] = nv;
    end
    if (we) m_ar[ws] = wd;
    if (ld) m_ptr = np;
  endtask

  // monitor: compare the ports with the queued expectation in mid-cycle
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #6;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check({it.tag, " addr"}, 128'(addr_out), 128'(it.addr));
        check({it.tag, " ptr"},  128'(ptr_out),  128'(it.ptr));
        check({it.tag, " regs"}, ar_flat, it.flat);
      end
    end
  end

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] br_fwd [8] = '{16'd0, 16'd4, 16'd2, 16'd6, 16'd1, 16'd5, 16'd3, 16'd7};
    logic [15:0] br_bwd [8] = '{16'd0, 16'd7, 16'd3, 16'd5, 16'd1, 16'd6, 16'd2, 16'd4};
    for (int i = 0; i < 8; i++) m_ar[i] = '0;
    m_ptr = '0;
    #20;
    check("R1 reset regs", ar_flat, '0);
    check("R1 reset ptr", 128'(ptr_out), '0);
    rst_n = 1'b1;

    op(0, 0, 0, 0, 1, 0, 16'd4,    "R9 write ar0");
    op(0, 0, 0, 0, 1, 1, 16'h00FF, "R9 write ar1");
    op(0, 0, 0, 0, 1, 2, 16'hFFFF, "R9 write ar2");
    op(0, 0, 1, 2, 0, 0, 0,        "R8 load ptr");
    op(1, 1, 0, 0, 0, 0, 0,        "R4 inc wrap");
    op(1, 2, 0, 0, 0, 0, 0,        "R4 dec wrap");
    op(1, 0, 0, 0, 0, 0, 0,        "R3 hold");
    op(1, 7, 0, 0, 0, 0, 0,        "R3 reserved");
    op(0, 1, 0, 0, 0, 0, 0,        "R10 idle mode");
    op(0, 5, 1, 1, 0, 0, 0,        "R10 idle rvadd");
    op(1, 3, 0, 0, 0, 0, 0,        "R5 add ix");
    op(1, 4, 0, 0, 0, 0, 0,        "R5 sub ix");
    op(1, 4, 0, 0, 0, 0, 0,        "R5 sub ix again");
    op(1, 1, 1, 3, 0, 0, 0,        "R8 modify old ptr");
    for (int i = 0; i < 8; i++) begin
      if (m_ar[3] !== br_fwd[i]) begin fails++; $display("FAIL R6 model act=%h exp=%h", m_ar[3], br_fwd[i]); end
      op(1, 5, 0, 0, 0, 0, 0, "R6 rev add");
    end
    for (int i = 0; i < 8; i++) begin
      if (m_ar[3] !== br_bwd[i]) begin fails++; $display("FAIL R7 model act=%h exp=%h", m_ar[3], br_bwd[i]); end
      op(1, 6, 0, 0, 0, 0, 0, "R7 rev sub");
    end
    op(1, 3, 1, 0, 0, 0, 0,        "R6 after loop");
    op(1, 3, 1, 3, 0, 0, 0,        "R11 ar0 self add");
    op(1, 1, 0, 0, 1, 3, 16'h1234, "R9 collide write wins");
    op(1, 1, 0, 0, 1, 5, 16'hBEEF, "R9 write other reg");
    op(0, 0, 0, 0, 0, 0, 0,        "R9 final state");
    op(0, 0, 0, 0, 0, 0, 0,        "R2 settle");
    @(posedge clk); @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear regs", ar_flat, '0);
    check("R1 async clear ptr", 128'(ptr_out), '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule